// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block holds a calendar time: seconds, minutes, hours, day of week, day of month, month and a two-digit year. Each cycle in which the advance strobe is high moves the time forward by exactly one second, with all carries resolved in the same cycle. That includes the month lengths and February 29 in leap years. Internally every field is kept as a plain binary number. The outputs present each field as a byte in the encoding chosen by two mode inputs: BCD or binary, and 12-hour or 24-hour with a PM flag.

A host that wants to set the clock raises the set-mode input and places the new register bytes on the load port. Those bytes must be written in the encoding currently selected. When set mode is released, the bytes are decoded into the internal counter. The two-digit year is taken to mean 2000 to 2099, so a year divisible by 4 is a leap year. Day of week counts 0 to 6.

Top module: `cal_clock_core`

## Requirements
- R1: After reset the time is 00:00:00 on day of week 6, day 1, month 1, year 00. With BCD and 24-hour modes selected, the outputs read 00, 00, 00, 06, 01, 01, 00.
- R2: On an advance, seconds past 59 wrap to 0 and carry into minutes. Minutes past 59 wrap to 0 and carry into hours. Hours past 23 wrap to 0 and carry into the day.
- R3: A day carry increments the day of week, and day of week 6 rolls to 0.
- R4: Months 1, 3, 5, 7, 8, 10 and 12 have 31 days. Months 4, 6, 9 and 11 have 30 days. A day carry past the last day of a month sets the day of month to 1 and increments the month.
- R5: February has 29 days when the two-digit year is divisible by 4, and 28 days otherwise.
- R6: A month carry from month 12 sets the month to 1 and increments the year, and year 99 rolls to 00.
- R7: With the binary-mode input low, every output byte is BCD: upper nibble holds the tens digit and lower nibble the units digit. With it high, each byte carries the value unchanged with bit 7 clear.
- R8: With the 24-hour input low, the hour byte shows 1 to 12 in the current data encoding, and bit 7 is set for hours 12 to 23. Hour 0 shows as 12 with bit 7 clear. With the 24-hour input high, the hour byte shows 0 to 23 with bit 7 clear.
- R9: The load-port bytes are decoded with the current modes and copied into the counter only in the cycle in which set mode goes from high to low. While set mode stays high or stays low, the load bytes have no effect. In 12-hour loads, 12 with bit 7 clear gives hour 0, 12 with bit 7 set gives hour 12, and bit 7 set adds 12 to any other hour.
- R10: In the cycle in which a load takes effect, an advance strobe is ignored.
- R11: In a cycle with no advance strobe and no load, the time does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Advance the time by one second this cycle |
| bin_mode_i | input | 1 | 1 selects binary data, 0 selects BCD |
| h24_mode_i | input | 1 | 1 selects 24-hour, 0 selects 12-hour with PM flag |
| set_mode_i | input | 1 | Host set mode; its falling edge loads the load port |
| ld_sec_i | input | 8 | Seconds byte to load |
| ld_min_i | input | 8 | Minutes byte to load |
| ld_hour_i | input | 8 | Hours byte to load (bit 7 is PM in 12-hour mode) |
| ld_wday_i | input | 8 | Day-of-week byte to load |
| ld_mday_i | input | 8 | Day-of-month byte to load |
| ld_mon_i | input | 8 | Month byte to load |
| ld_year_i | input | 8 | Two-digit year byte to load |
| sec_o | output | 8 | Encoded seconds |
| min_o | output | 8 | Encoded minutes |
| hour_o | output | 8 | Encoded hours |
| wday_o | output | 8 | Encoded day of week |
| mday_o | output | 8 | Encoded day of month |
| mon_o | output | 8 | Encoded month |
| year_o | output | 8 | Encoded two-digit year |

## Verification
The bench builds the block with its default parameters. The reset date is therefore day 1 of month 1 of year 00, a day-of-week 6, and the reset check pins those values. Every other corner is reached by loading a chosen time through the set-mode release and then advancing it. This covers a year-end rollover from 99, February in a leap year and in a common year, 30- and 31-day month ends, and noon and midnight in 12-hour form. The same internal time is read back in both data encodings and both hour formats, so that encode and decode paths can be checked against each other.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int BYTE_W  = 8;
    localparam int FIELD_W = 7;

    typedef logic [FIELD_W-1:0] fld_t;
    typedef logic [BYTE_W-1:0]  byte_t;

    typedef struct packed {
        fld_t sec;
        fld_t min;
        fld_t hour;
        fld_t wday;
        fld_t mday;
        fld_t mon;
        fld_t year;
    } cal_time_t;

    typedef struct packed {
        cal_time_t t;
        logic      set_seen;
    } core_state_t;

    // binary field value -> register byte
    function automatic byte_t enc_fld(fld_t v, logic bin);
        fld_t tens;
        fld_t units;
        tens  = v / FIELD_W'(10);
        units = v % FIELD_W'(10);
        if (bin) return {1'b0, v};
        return {tens[3:0], units[3:0]};
    endfunction

    // register byte -> binary field value
    function automatic fld_t dec_fld(byte_t b, logic bin);
        if (bin) return b[FIELD_W-1:0];
        return FIELD_W'(b[7:4]) * FIELD_W'(10) + FIELD_W'(b[3:0]);
    endfunction

    function automatic byte_t enc_hour(fld_t h, logic bin, logic h24);
        fld_t  h12;
        byte_t r;
        if (h24) return enc_fld(h, bin);
        h12 = h % FIELD_W'(12);
        if (h12 == '0) h12 = FIELD_W'(12);
        r    = enc_fld(h12, bin);
        r[7] = (h >= FIELD_W'(12));
        return r;
    endfunction

    function automatic fld_t dec_hour(byte_t b, logic bin, logic h24);
        fld_t raw;
        raw = dec_fld({1'b0, b[6:0]}, bin);
        if (!h24) begin
            if (raw == FIELD_W'(12)) raw = '0;
            if (b[7]) raw = raw + FIELD_W'(12);
        end
        return raw;
    endfunction

    // year is two-digit within 2000..2099
    function automatic fld_t month_len(fld_t mon, fld_t year);
        case (mon)
            FIELD_W'(2):  return (year[1:0] == 2'b00) ? FIELD_W'(29) : FIELD_W'(28);
            FIELD_W'(4), FIELD_W'(6),
            FIELD_W'(9), FIELD_W'(11): return FIELD_W'(30);
            default:      return FIELD_W'(31);
        endcase
    endfunction

endpackage

// File: rtl/cal_step.sv
module cal_step
    import cal_pkg::*;
(
    input  cal_time_t cur,
    output cal_time_t nxt
);
    localparam fld_t LAST_SEC  = FIELD_W'(59);
    localparam fld_t LAST_HOUR = FIELD_W'(23);
    localparam fld_t LAST_WDAY = FIELD_W'(6);
    localparam fld_t LAST_MON  = FIELD_W'(12);
    localparam fld_t LAST_YEAR = FIELD_W'(99);

    fld_t dim;

    always_comb begin
        nxt = cur;
        dim = month_len(cur.mon, cur.year);
        if (cur.sec < LAST_SEC) begin
            nxt.sec = cur.sec + 1'b1;
        end else begin
            nxt.sec = '0;
            if (cur.min < LAST_SEC) begin
                nxt.min = cur.min + 1'b1;
            end else begin
                nxt.min = '0;
                if (cur.hour < LAST_HOUR) begin
                    nxt.hour = cur.hour + 1'b1;
                end else begin
                    nxt.hour = '0;
                    nxt.wday = (cur.wday < LAST_WDAY) ? cur.wday + 1'b1 : '0;
                    if (cur.mday < dim) begin
                        nxt.mday = cur.mday + 1'b1;
                    end else begin
                        nxt.mday = FIELD_W'(1);
                        if (cur.mon < LAST_MON) begin
                            nxt.mon = cur.mon + 1'b1;
                        end else begin
                            nxt.mon  = FIELD_W'(1);
                            nxt.year = (cur.year < LAST_YEAR) ? cur.year + 1'b1 : '0;
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/cal_load.sv
module cal_load
    import cal_pkg::*;
(
    input  byte_t     sec_b,
    input  byte_t     min_b,
    input  byte_t     hour_b,
    input  byte_t     wday_b,
    input  byte_t     mday_b,
    input  byte_t     mon_b,
    input  byte_t     year_b,
    input  logic      bin,
    input  logic      h24,
    output cal_time_t t
);
    always_comb begin
        t.sec  = dec_fld(sec_b, bin);
        t.min  = dec_fld(min_b, bin);
        t.hour = dec_hour(hour_b, bin, h24);
        t.wday = dec_fld(wday_b, bin);
        t.mday = dec_fld(mday_b, bin);
        t.mon  = dec_fld(mon_b, bin);
        t.year = dec_fld(year_b, bin);
    end

endmodule

// File: rtl/cal_present.sv
module cal_present
    import cal_pkg::*;
#(
    parameter int N_PLAIN = 6
) (
    input  cal_time_t t,
    input  logic      bin,
    input  logic      h24,
    output byte_t     plain_b [N_PLAIN],
    output byte_t     hour_b
);
    fld_t plain_v [N_PLAIN];

    assign plain_v[0] = t.sec;
    assign plain_v[1] = t.min;
    assign plain_v[2] = t.wday;
    assign plain_v[3] = t.mday;
    assign plain_v[4] = t.mon;
    assign plain_v[5] = t.year;

    for (genvar i = 0; i < N_PLAIN; i++) begin : g_plain
        assign plain_b[i] = enc_fld(plain_v[i], bin);
    end

    assign hour_b = enc_hour(t.hour, bin, h24);

endmodule

// File: rtl/cal_clock_core.sv
module cal_clock_core
    import cal_pkg::*;
#(
    parameter int RST_WDAY = 6,
    parameter int RST_MDAY = 1,
    parameter int RST_MON  = 1,
    parameter int RST_YEAR = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       bin_mode_i,
    input  logic       h24_mode_i,
    input  logic       set_mode_i,
    input  logic [7:0] ld_sec_i,
    input  logic [7:0] ld_min_i,
    input  logic [7:0] ld_hour_i,
    input  logic [7:0] ld_wday_i,
    input  logic [7:0] ld_mday_i,
    input  logic [7:0] ld_mon_i,
    input  logic [7:0] ld_year_i,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] wday_o,
    output logic [7:0] mday_o,
    output logic [7:0] mon_o,
    output logic [7:0] year_o
);
    localparam int N_PLAIN = 6;

    localparam cal_time_t RST_TIME = '{
        sec:  '0,
        min:  '0,
        hour: '0,
        wday: FIELD_W'(RST_WDAY),
        mday: FIELD_W'(RST_MDAY),
        mon:  FIELD_W'(RST_MON),
        year: FIELD_W'(RST_YEAR)
    };

    core_state_t state_d;
    core_state_t state_q;
    cal_time_t   stepped;
    cal_time_t   loaded;
    logic        load_ev;
    byte_t       plain_b [N_PLAIN];
    byte_t       hour_b;

    cal_step u_step (
        .cur (state_q.t),
        .nxt (stepped)
    );

    cal_load u_load (
        .sec_b  (ld_sec_i),
        .min_b  (ld_min_i),
        .hour_b (ld_hour_i),
        .wday_b (ld_wday_i),
        .mday_b (ld_mday_i),
        .mon_b  (ld_mon_i),
        .year_b (ld_year_i),
        .bin    (bin_mode_i),
        .h24    (h24_mode_i),
        .t      (loaded)
    );

    cal_present #(.N_PLAIN(N_PLAIN)) u_present (
        .t       (state_q.t),
        .bin     (bin_mode_i),
        .h24     (h24_mode_i),
        .plain_b (plain_b),
        .hour_b  (hour_b)
    );

    assign load_ev = state_q.set_seen & ~set_mode_i;

    always_comb begin
        state_d          = state_q;
        state_d.set_seen = set_mode_i;
        if (load_ev) begin
            state_d.t = loaded;
        end else if (tick_i) begin
            state_d.t = stepped;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.t        <= RST_TIME;
            state_q.set_seen <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sec_o  = plain_b[0];
    assign min_o  = plain_b[1];
    assign wday_o = plain_b[2];
    assign mday_o = plain_b[3];
    assign mon_o  = plain_b[4];
    assign year_o = plain_b[5];
    assign hour_o = hour_b;

endmodule

// File: rtl/cal_clock_chk.sv
module cal_clock_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic       bin_mode_i,
    input logic       h24_mode_i,
    input logic       set_mode_i,
    input logic [7:0] ld_sec_i,
    input logic [7:0] sec_o,
    input logic [7:0] min_o,
    input logic [7:0] hour_o
);
    logic prev_set;
    logic load_ev;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_set <= 1'b0;
        else        prev_set <= set_mode_i;
    end

    assign load_ev = prev_set & ~set_mode_i;

    // R11: no strobe, no load, same modes -> outputs hold
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_ev) |=>
        (!$stable(bin_mode_i) || !$stable(h24_mode_i) ||
         ($stable(sec_o) && $stable(min_o) && $stable(hour_o))));

    // R2: seconds wrap from 59 to 0
    a_r2_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_ev && bin_mode_i && sec_o == 8'd59) |=>
        (!bin_mode_i || sec_o == 8'd0));

    // R10: a load wins over an advance in the same cycle
    a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (load_ev && bin_mode_i && ld_sec_i < 8'd60) |=>
        (!bin_mode_i || sec_o == $past(ld_sec_i)));

    // R7: BCD units digit never exceeds 9
    a_r7_bcd_units: assert property (@(posedge clk) disable iff (!rst_n)
        !bin_mode_i |-> (sec_o[3:0] <= 4'd9 && min_o[3:0] <= 4'd9));

    // R8: 11:59:59 AM advances to 12 PM in 12-hour BCD form
    a_r8_noon: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_ev && !h24_mode_i && !bin_mode_i &&
         hour_o == 8'h11 && min_o == 8'h59 && sec_o == 8'h59) |=>
        (h24_mode_i || bin_mode_i || hour_o == 8'h92));

endmodule

bind cal_clock_core cal_clock_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .bin_mode_i (bin_mode_i),
    .h24_mode_i (h24_mode_i),
    .set_mode_i (set_mode_i),
    .ld_sec_i   (ld_sec_i),
    .sec_o      (sec_o),
    .min_o      (min_o),
    .hour_o     (hour_o)
);

// File: tb/sim_cal_clock_core.sv
module sim_cal_clock_core;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        string      req;
        logic [7:0] v [7];
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       bin = 1'b0;
    logic       h24 = 1'b1;
    logic       setm = 1'b0;
    logic [7:0] ld [7];
    logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;
    exp_t q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cal_clock_core u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .bin_mode_i (bin),
        .h24_mode_i (h24),
        .set_mode_i (setm),
        .ld_sec_i   (ld[0]),
        .ld_min_i   (ld[1]),
        .ld_hour_i  (ld[2]),
        .ld_wday_i  (ld[3]),
        .ld_mday_i  (ld[4]),
        .ld_mon_i   (ld[5]),
        .ld_year_i  (ld[6]),
        .sec_o      (sec_o),
        .min_o      (min_o),
        .hour_o     (hour_o),
        .wday_o     (wday_o),
        .mday_o     (mday_o),
        .mon_o      (mon_o),
        .year_o     (year_o)
    );

    // monitor: compare against scoreboard at falling edges
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            logic [7:0] act [7];
            e = q.pop_front();
            act = '{sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o};
            checks++;
            if (act != e.v) begin
                fails++;
                $display("FAIL %s: actual s=%h m=%h h=%h wd=%h d=%h mo=%h y=%h expected s=%h m=%h h=%h wd=%h d=%h mo=%h y=%h",
                    e.req, act[0], act[1], act[2], act[3], act[4], act[5], act[6],
                    e.v[0], e.v[1], e.v[2], e.v[3], e.v[4], e.v[5], e.v[6]);
            end
        end
    end

    task automatic expect_t(string req, logic [7:0] s, logic [7:0] m, logic [7:0] h,
                            logic [7:0] wd, logic [7:0] d, logic [7:0] mo, logic [7:0] y);
        exp_t e;
        e.req = req;
        e.v = '{s, m, h, wd, d, mo, y};
        q.push_back(e);
        @(negedge clk);
        #1;
    endtask

    task automatic advance(int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(posedge clk);
            #1;
        end
        tick = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic load(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] wd,
                        logic [7:0] d, logic [7:0] mo, logic [7:0] y, logic with_tick);
        setm = 1'b1;
        @(posedge clk);
        #1;
        setm = 1'b0;
        ld = '{s, m, h, wd, d, mo, y};
        tick = with_tick;
        @(posedge clk);
        #1;
        tick = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        ld = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        idle(3);
        rst_n = 1'b1;
        @(negedge clk); #1;
        expect_t("R1 reset", 8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h01, 8'h00);

        // R10 tick during load is ignored, R9 load on set release
        load(8'h58, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99, 1'b1);
        expect_t("R10 load beats tick", 8'h58, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
        advance(1);
        expect_t("R11 one second", 8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
        advance(1);
        expect_t("R6 year end rollover", 8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h01, 8'h00);
        idle(3);
        expect_t("R11 hold without tick", 8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h01, 8'h00);

        // R9 load bytes ignored while set mode stays high
        setm = 1'b1;
        ld = '{8'h12, 8'h34, 8'h05, 8'h02, 8'h09, 8'h07, 8'h45};
        idle(4);
        expect_t("R9 no load while set held", 8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h01, 8'h00);
        setm = 1'b0;
        idle(1);
        expect_t("R9 load on release", 8'h12, 8'h34, 8'h05, 8'h02, 8'h09, 8'h07, 8'h45);

        load(8'h59, 8'h59, 8'h23, 8'h06, 8'h28, 8'h02, 8'h24, 1'b0);
        advance(1);
        expect_t("R5 leap Feb 29 and R3 wday wrap", 8'h00, 8'h00, 8'h00, 8'h00, 8'h29, 8'h02, 8'h24);
        load(8'h59, 8'h59, 8'h23, 8'h00, 8'h29, 8'h02, 8'h24, 1'b0);
        advance(1);
        expect_t("R5 leap Feb end", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h03, 8'h24);
        load(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 1'b0);
        advance(1);
        expect_t("R5 common Feb end", 8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h03, 8'h23);
        load(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h23, 1'b0);
        advance(1);
        expect_t("R4 30-day month end", 8'h00, 8'h00, 8'h00, 8'h04, 8'h01, 8'h05, 8'h23);
        load(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h01, 8'h23, 1'b0);
        advance(1);
        expect_t("R4 31-day month day 31", 8'h00, 8'h00, 8'h00, 8'h02, 8'h31, 8'h01, 8'h23);
        load(8'h59, 8'h59, 8'h10, 8'h01, 8'h15, 8'h06, 8'h23, 1'b0);
        advance(1);
        expect_t("R2 minute and hour carry", 8'h00, 8'h00, 8'h11, 8'h01, 8'h15, 8'h06, 8'h23);

        // 12-hour presentation and loading
        h24 = 1'b0;
        expect_t("R8 12h AM view", 8'h00, 8'h00, 8'h11, 8'h01, 8'h15, 8'h06, 8'h23);
        load(8'h00, 8'h00, 8'h92, 8'h01, 8'h15, 8'h06, 8'h23, 1'b0);
        expect_t("R8 12h PM view", 8'h00, 8'h00, 8'h92, 8'h01, 8'h15, 8'h06, 8'h23);
        h24 = 1'b1;
        expect_t("R9 12 PM loads as 12", 8'h00, 8'h00, 8'h12, 8'h01, 8'h15, 8'h06, 8'h23);
        h24 = 1'b0;
        load(8'h00, 8'h00, 8'h12, 8'h01, 8'h15, 8'h06, 8'h23, 1'b0);
        h24 = 1'b1;
        expect_t("R9 12 AM loads as 0", 8'h00, 8'h00, 8'h00, 8'h01, 8'h15, 8'h06, 8'h23);
        h24 = 1'b0;
        load(8'h00, 8'h00, 8'h81, 8'h01, 8'h15, 8'h06, 8'h23, 1'b0);
        h24 = 1'b1;
        expect_t("R9 1 PM loads as 13", 8'h00, 8'h00, 8'h13, 8'h01, 8'h15, 8'h06, 8'h23);
        h24 = 1'b0;
        load(8'h59, 8'h59, 8'h11, 8'h01, 8'h15, 8'h06, 8'h23, 1'b0);
        advance(1);
        expect_t("R8 noon", 8'h00, 8'h00, 8'h92, 8'h01, 8'h15, 8'h06, 8'h23);
        load(8'h59, 8'h59, 8'h91, 8'h01, 8'h15, 8'h06, 8'h23, 1'b0);
        advance(1);
        expect_t("R8 midnight", 8'h00, 8'h00, 8'h12, 8'h02, 8'h16, 8'h06, 8'h23);

        // binary data mode
        bin = 1'b1;
        h24 = 1'b1;
        load(8'd45, 8'd30, 8'd17, 8'd4, 8'd20, 8'd11, 8'd57, 1'b0);
        expect_t("R7 binary load", 8'd45, 8'd30, 8'd17, 8'd4, 8'd20, 8'd11, 8'd57);
        advance(1);
        expect_t("R7 binary advance", 8'd46, 8'd30, 8'd17, 8'd4, 8'd20, 8'd11, 8'd57);
        h24 = 1'b0;
        expect_t("R8 binary 12h PM", 8'd46, 8'd30, 8'h85, 8'd4, 8'd20, 8'd11, 8'd57);
        bin = 1'b0;
        h24 = 1'b1;
        expect_t("R7 BCD view of same time", 8'h46, 8'h30, 8'h17, 8'h04, 8'h20, 8'h11, 8'h57);

        idle(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule